// File: doc/BRIEF.md
# Serial Register-Access Port

This block is the slave side of a serial control link. An external master frames each transaction by pulling the chip-select line low. It then clocks in a 16-bit instruction. That instruction selects read or write, a transfer length and a starting byte address. The data bytes that follow are read from, or written to, a byte-wide register map that sits outside this block. The map connects through a plain address / write-data / write-strobe / read-data interface. Every serial line is sampled on the system clock, and the block finds the serial clock's edges itself.

The port holds one configuration byte of its own, at address zero. It controls two settings. The first is the bit order on the wire: most significant bit first (the default) or least significant bit first. The second is where read data is returned: on the shared data line (3-wire, the default) or on a separate output pin (4-wire). Each setting is written in both halves of the byte, mirrored, so the byte decodes the same way in either bit order. The bit order also sets the direction of the address sequencer. In MSB-first order the address counts down after each byte, and in LSB-first order it counts up. Streaming transfers stop automatically at the top of the map.

Top module: `spi_regport`

## Requirements
- R1: After reset, sdio_oe and reg_we are low, and the configuration byte at address 0x000 reads back as 0x18: MSB-first order and 3-wire read mode.
- R2: The instruction word has 16 bits. Bit 15 set means read and clear means write. Bits 14:13 give the length code. Bits 12:0 give the start address, of which only the low AW bits are used. The word is shifted in the current bit order.
- R3: A length code of 0, 1 or 2 moves 1, 2 or 3 data bytes. In a write, each completed byte gives exactly one single-cycle reg_we pulse, with reg_addr and reg_wdata holding the byte's address and value. In MSB-first order the address steps down by one after each byte.
- R4: In LSB-first order, both the instruction and the data bytes are shifted least significant bit first, and the address steps up by one after each byte.
- R5: Length code 3 streams bytes until CS rises. When the address steps up, streaming ends after the byte at address TOP (default 0x232), and later bytes give no strobe.
- R6: When the address steps down while streaming, address 0x000 is followed by TOP. The byte at TOP is the last one handled.
- R7: Read data is taken from reg_rdata, or from the configuration byte at address 0x000. It is driven in the current bit order. Each bit changes only after an SCLK falling edge, so it is stable for the master's next rising edge. In 3-wire mode, read data appears on sdio_o with sdio_oe high.
- R8: When configuration bit 0 (mirrored in bit 7) is set, read data appears on sdo and sdio_oe stays low.
- R9: A write to address 0x000 updates the configuration at once and gives no reg_we. Bit 1 (mirrored in bit 6) selects LSB-first order. Readback returns the settings mirrored in both nibbles, with bits 3 and 4 set.
- R10: If CS rises in the middle of a byte, that byte is discarded: no strobe is given, and the next transaction starts again at the instruction phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low transaction frame |
| sdio_i | input | 1 | Serial data in (instruction and write data) |
| sdio_o | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Read data in 4-wire mode |
| reg_addr | output | AW | Register map byte address |
| reg_wdata | output | 8 | Register map write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register map read data for reg_addr |

## Verification
The assertions assume that sclk, cs_n and sdio_i are already synchronous to clk and that each SCLK phase lasts several system clocks. They also assume that every instruction names an address no higher than TOP, and that cs_n is high during reset. The bench drives every serial line just after a clock edge. It holds each SCLK level for four system cycles and keeps SCLK low whenever it changes CS. It uses only start addresses inside the map, so the address-range property and the single-pulse strobe property rest on conditions the stimulus always meets.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW = 10,
  parameter logic [AW-1:0] TOP = 10'h232
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdio_i,
  output logic          sdio_o,
  output logic          sdio_oe,
  output logic          sdo,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);
  localparam logic [1:0] PH_CMD = 2'd0, PH_DAT = 2'd1, PH_END = 2'd2;

  logic          sclk_q, rd_op, wrapped, lsb_first, sdo_en, dout, we_q;
  logic [1:0]    phase, len, nbyte;
  logic [3:0]    cnt;
  logic [15:0]   sr;
  logic [AW-1:0] addr, wa_q;
  logic [7:0]    wd_q;

  wire rise = sclk & ~sclk_q;
  wire fall = ~sclk & sclk_q;
  wire [15:0] sr_n = lsb_first ? {sdio_i, sr[15:1]} : {sr[14:0], sdio_i};
  wire [7:0]  by_n = lsb_first ? {sdio_i, sr[7:1]} : {sr[6:0], sdio_i};
  wire [7:0]  cfg  = {sdo_en, lsb_first, 1'b0, 1'b1, 1'b1, 1'b0, lsb_first, sdo_en};
  wire [7:0]  rbyte = (addr == '0) ? cfg : reg_rdata;
  wire [2:0]  ridx = lsb_first ? cnt[2:0] : 3'd7 - cnt[2:0];
  wire last_byte = (len != 2'd3 && nbyte == len) || (lsb_first ? addr == TOP : wrapped);

  assign reg_addr  = we_q ? wa_q : addr;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;
  assign sdio_o    = dout;
  assign sdio_oe   = ~cs_n && phase == PH_DAT && rd_op && ~sdo_en;
  assign sdo       = sdo_en ? dout : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; phase <= PH_CMD; cnt <= '0; sr <= '0;
      rd_op <= 1'b0; len <= '0; nbyte <= '0; addr <= '0; wrapped <= 1'b0;
      lsb_first <= 1'b0; sdo_en <= 1'b0; dout <= 1'b0;
      we_q <= 1'b0; wa_q <= '0; wd_q <= '0;
    end else begin
      sclk_q <= sclk;
      we_q   <= 1'b0;
      if (cs_n) begin
        phase <= PH_CMD; cnt <= '0; sr <= '0; dout <= 1'b0;
      end else if (rise && phase == PH_CMD) begin
        sr  <= sr_n;
        cnt <= cnt + 4'd1;
        if (cnt == 4'd15) begin
          phase <= PH_DAT; cnt <= '0; sr <= '0;
          rd_op <= sr_n[15]; len <= sr_n[14:13];
          addr <= sr_n[AW-1:0]; nbyte <= '0; wrapped <= 1'b0;
        end
      end else if (rise && phase == PH_DAT) begin
        sr[7:0] <= by_n;
        cnt <= cnt + 4'd1;
        if (cnt == 4'd7) begin
          cnt <= '0;
          if (!rd_op) begin
            if (addr == '0) begin
              lsb_first <= by_n[1];
              sdo_en    <= by_n[0];
            end else begin
              we_q <= 1'b1; wa_q <= addr; wd_q <= by_n;
            end
          end
          nbyte <= nbyte + 2'd1;
          if (last_byte) phase <= PH_END;
          else begin
            addr    <= lsb_first ? addr + 1'b1 : (addr == '0 ? TOP : addr - 1'b1);
            wrapped <= wrapped | (~lsb_first & (addr == '0));
          end
        end
      end else if (fall && phase == PH_DAT && rd_op) begin
        dout <= rbyte[ridx];
      end
    end
  end
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int AW = 10,
  parameter logic [AW-1:0] TOP = 10'h232
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          cs_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          sdio_oe,
  input logic          sdo_en
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R3
  AST_WE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(sclk)); // R3
  AST_WE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !reg_we); // R10
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr <= TOP); // R2
  AST_NO_CFG_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_addr != '0); // R9
  AST_LINE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !sdo_en); // R8
endmodule

bind spi_regport spi_regport_chk #(.AW(AW), .TOP(TOP)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .reg_we(reg_we),
  .reg_addr(reg_addr), .sdio_oe(sdio_oe), .sdo_en(sdo_en)
);

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo, reg_we;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  int checks = 0, fails = 0, log_n = 0, oe_cnt = 0;
  logic [9:0] log_a [64];
  logic [7:0] log_d [64];
  bit lsb_tb = 0, sdo_tb = 0, ended = 0;

  always #2 clk = ~clk;
  assign reg_rdata = reg_addr[7:0] ^ 8'hA5;

  spi_regport dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    if (reg_we && log_n < 64) begin
      log_a[log_n] <= reg_addr; log_d[log_n] <= reg_wdata; log_n <= log_n + 1;
    end
    if (sdio_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    @(posedge clk); #1 sclk = 1'b0; sdio_i = b;
    repeat (3) @(posedge clk);
    #1 r = sdo_tb ? sdo : sdio_o;
    @(posedge clk); #1 sclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic cmd(input bit rd, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w; logic r;
    w = {rd, len, a};
    @(posedge clk); #1 cs_n = 1'b0;
    for (int i = 0; i < 16; i++) xbit(lsb_tb ? w[i] : w[15-i], r);
  endtask

  task automatic dbyte(input logic [7:0] d, output logic [7:0] q);
    logic r;
    for (int i = 0; i < 8; i++) begin
      int idx = lsb_tb ? i : 7 - i;
      xbit(d[idx], r);
      q[idx] = r;
    end
  endtask

  task automatic endcmd();
    @(posedge clk); #1 sclk = 1'b0;
    repeat (2) @(posedge clk); #1 cs_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R1 oe", sdio_oe, 0);
    chk("R1 we", reg_we, 0);
    cmd(1, 2'd0, 13'h000); dbyte(8'h00, q); endcmd();
    chk("R1 cfg", q, 8'h18);
  endtask

  task automatic t_write3_msb();
    int b = log_n; logic [7:0] q;
    cmd(0, 2'd2, 13'h100);
    dbyte(8'hC3, q); dbyte(8'h3C, q); dbyte(8'h7E, q); endcmd();
    chk("R3 count", log_n - b, 3);
    chk("R3 a0", log_a[b], 10'h100);   chk("R3 d0", log_d[b], 8'hC3);
    chk("R3 a1", log_a[b+1], 10'h0FF); chk("R3 d1", log_d[b+1], 8'h3C);
    chk("R3 a2", log_a[b+2], 10'h0FE); chk("R3 d2", log_d[b+2], 8'h7E);
  endtask

  task automatic t_read_msb();
    logic [7:0] q0, q1;
    int oe0 = oe_cnt;
    cmd(1, 2'd1, 13'h041); dbyte(8'h00, q0); dbyte(8'h00, q1); endcmd();
    chk("R7 byte0", q0, 8'h41 ^ 8'hA5);
    chk("R7 byte1", q1, 8'h40 ^ 8'hA5);
    chk("R2 read flag drives oe", oe_cnt > oe0, 1);
  endtask

  task automatic t_stream_down();
    int b = log_n; logic [7:0] q;
    cmd(0, 2'd3, 13'h001);
    dbyte(8'h11, q); dbyte(8'h18, q); dbyte(8'h22, q); dbyte(8'h33, q); endcmd();
    chk("R6 count", log_n - b, 2);
    chk("R6 a0", log_a[b], 10'h001);   chk("R6 d0", log_d[b], 8'h11);
    chk("R6 wrap", log_a[b+1], 10'h232); chk("R6 d1", log_d[b+1], 8'h22);
  endtask

  task automatic t_cfg_lsb();
    int b = log_n; logic [7:0] q;
    cmd(0, 2'd0, 13'h000); dbyte(8'h42, q); endcmd();
    chk("R9 no strobe", log_n - b, 0);
    lsb_tb = 1;
    cmd(1, 2'd0, 13'h000); dbyte(8'h00, q); endcmd();
    chk("R9 readback", q, 8'h5A);
  endtask

  task automatic t_lsb_write();
    int b = log_n; logic [7:0] q;
    cmd(0, 2'd1, 13'h020); dbyte(8'h96, q); dbyte(8'h0F, q); endcmd();
    chk("R4 count", log_n - b, 2);
    chk("R4 a0", log_a[b], 10'h020);   chk("R4 d0", log_d[b], 8'h96);
    chk("R4 a1", log_a[b+1], 10'h021); chk("R4 d1", log_d[b+1], 8'h0F);
    cmd(1, 2'd0, 13'h033); dbyte(8'h00, q); endcmd();
    chk("R4 read lsb", q, 8'h33 ^ 8'hA5);
  endtask

  task automatic t_stream_up();
    int b = log_n; logic [7:0] q;
    cmd(0, 2'd3, 13'h230);
    dbyte(8'hA1, q); dbyte(8'hB2, q); dbyte(8'hC3, q); dbyte(8'hD4, q); endcmd();
    chk("R5 count", log_n - b, 3);
    chk("R5 a0", log_a[b], 10'h230);
    chk("R5 a2", log_a[b+2], 10'h232); chk("R5 d2", log_d[b+2], 8'hC3);
    cmd(0, 2'd0, 13'h000); dbyte(8'h18, q); endcmd();
    lsb_tb = 0;
  endtask

  task automatic t_sdo_mode();
    logic [7:0] q; int oe0;
    cmd(0, 2'd0, 13'h000); dbyte(8'h81, q); endcmd();
    sdo_tb = 1;
    oe0 = oe_cnt;
    cmd(1, 2'd0, 13'h05C); dbyte(8'h00, q); endcmd();
    chk("R8 sdo data", q, 8'h5C ^ 8'hA5);
    chk("R8 oe low", oe_cnt - oe0, 0);
    cmd(0, 2'd0, 13'h000); dbyte(8'h18, q); endcmd();
    sdo_tb = 0;
  endtask

  task automatic t_abort();
    int b = log_n; logic r; logic [7:0] q;
    cmd(0, 2'd0, 13'h010);
    for (int i = 0; i < 5; i++) xbit(1'b1, r);
    endcmd();
    chk("R10 no strobe", log_n - b, 0);
    cmd(0, 2'd0, 13'h011); dbyte(8'h5E, q); endcmd();
    chk("R10 recover count", log_n - b, 1);
    chk("R10 recover addr", log_a[b], 10'h011);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_write3_msb();
    t_read_msb();
    t_stream_down();
    t_cfg_lsb();
    t_lsb_write();
    t_stream_up();
    t_sdo_mode();
    t_abort();
    finish_run();
  end
endmodule